// File: doc/BRIEF.md
# Phase-Shifted Carrier Modulator for Series H-Bridge Cells

This block modulates one phase of a converter built from `N_CELLS` H-bridge cells whose outputs are stacked in series. Each cell owns a triangular carrier that sweeps from 0 to `PEAK` and back in `2*PEAK` clock cycles. All carriers share that frequency. Neighbouring cells are spread by `PEAK/N_CELLS` steps, which is one `2*N_CELLS`-th of a carrier period. One signed reference is shared by every cell. Each cell compares it with its own carrier and chooses positive, zero or negative. The stacked phase therefore takes one of `2*N_CELLS+1` levels.

A per-cell bypass request lets the controller remove a faulted cell from the stack. A bypassed cell is parked in its zero state with both low-side switches on. The remaining cells keep running, so the phase delivers a smaller total voltage. The request is taken into effect only at the end of a carrier period, so that a cell is never dropped in mid-pulse. The outputs are four gate bits per cell and the signed sum of the cell levels.

The outputs are combinational from the registered carrier state, the bypass state and the reference. A downstream dead-time stage is expected to register them. Parameter `ZERO_LOW` selects how an active cell forms its zero state. With the default of 0, the cell follows the sign of the reference. With 1, it always uses the low-side pair.

Top module: `pscar_modulator`

## Requirements
- R1: During reset and on the cycle it is released, cell i sits at phase i*PEAK/N_CELLS. After k rising edges with reset released, its phase is (i*PEAK/N_CELLS + k) mod 2*PEAK. Its carrier is the phase itself while the phase is below PEAK, and 2*PEAK minus the phase otherwise.
- R2: The carriers of adjacent cells are always PEAK/N_CELLS phase steps apart, and cell i+1 leads cell i.
- R3: An active cell whose carrier is below the reference outputs +1 with gate nibble 4'b1001. In the nibble, bit 0 is the left high side, bit 1 the left low side, bit 2 the right high side and bit 3 the right low side.
- R4: An active cell whose carrier is below the negated reference outputs -1 with gate nibble 4'b0110.
- R5: An active cell that is neither positive nor negative (a carrier equal to the reference counts as neither) outputs 0. With ZERO_LOW=0 its nibble is 4'b0101 when the reference is zero or positive, and 4'b1010 when it is negative.
- R6: No cell ever switches on both the high and the low side of the same leg.
- R7: level_o is the signed sum of the cell outputs and stays within plus or minus the number of active cells. Cell i drives gate_o bits 4i+3 down to 4i.
- R8: A bypassed cell drives 4'b1010 and contributes 0 to level_o, whatever the reference.
- R9: The bypass state loads bypass_i on the rising edge at which cell 0's phase wraps from 2*PEAK-1 to 0. A change of bypass_i at any other time has no effect until that edge.
- R10: Reset clears the bypass state, so that every cell is active, regardless of bypass_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_i | input | REF_W | Signed modulation reference, in carrier steps |
| bypass_i | input | N_CELLS | Bypass request, one bit per cell, 1 = bypass |
| gate_o | output | 4*N_CELLS | Gate drives, one nibble per cell |
| level_o | output | $clog2(N_CELLS+1)+1 | Signed sum of the cell output levels |

## Verification
Two events can land on the same edge: the bypass state reloading, and cell 0's carrier reaching its trough at the period wrap. Because both happen together, a bypassed cell must vanish from the sum exactly as a new period begins.

The bench raises a bypass request part-way through a period while holding the reference above the peak, so that every active cell is positive. It then checks level_o on every cycle. The level must stay at the full count up to the wrap and drop by one on the first cycle after it. Reset is then applied with every bypass bit requested. This confirms that the cleared state wins over the pending request until the next wrap.

// File: rtl/pscar_pkg.sv
package pscar_pkg;
   // Gate nibble: bit0 left-high, bit1 left-low, bit2 right-high, bit3 right-low
   localparam logic [3:0] GATE_POS = 4'b1001;
   localparam logic [3:0] GATE_NEG = 4'b0110;
   localparam logic [3:0] GATE_ZHI = 4'b0101;
   localparam logic [3:0] GATE_ZLO = 4'b1010;

   typedef enum logic [1:0] {
      CELL_ZERO = 2'd0,
      CELL_POS  = 2'd1,
      CELL_NEG  = 2'd2
   } cell_state_e;
endpackage

// File: rtl/pscar_carrier.sv
module pscar_carrier #(
   parameter int PEAK   = 12,
   parameter int OFFSET = 0,
   parameter int PH_W   = $clog2(2*PEAK),
   parameter int CAR_W  = $clog2(PEAK+1)
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [PH_W-1:0]  phase_o,
   output logic [CAR_W-1:0] carrier_o
);
   localparam int LAST = 2*PEAK - 1;

   logic [PH_W-1:0] phase_q;
   logic            seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_W'(OFFSET);
         seen_q  <= 1'b0;
      end else begin
         phase_q <= (phase_q == PH_W'(LAST)) ? '0 : phase_q + 1'b1;
         seen_q  <= 1'b1;
      end
   end

   logic [PH_W:0] fold;
   always_comb begin
      if (phase_q < PH_W'(PEAK)) fold = {1'b0, phase_q};
      else                       fold = (PH_W+1)'(2*PEAK) - {1'b0, phase_q};
   end

   assign phase_o   = phase_q;
   assign carrier_o = CAR_W'(fold);

   // R1
   carrier_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seen_q |-> ((carrier_o == $past(carrier_o) + 1'b1) || (carrier_o + 1'b1 == $past(carrier_o))));
endmodule

// File: rtl/pscar_cell.sv
module pscar_cell
   import pscar_pkg::*;
#(
   parameter int CAR_W    = 4,
   parameter int REF_W    = 6,
   parameter bit ZERO_LOW = 1'b0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic signed [REF_W-1:0] ref_i,
   input  logic [CAR_W-1:0]        carrier_i,
   input  logic                    bypass_i,
   output logic [3:0]              gate_o,
   output logic signed [1:0]       level_o
);
   localparam int CMP_W = ((REF_W > CAR_W + 1) ? REF_W : CAR_W + 1) + 1;

   logic signed [CMP_W-1:0] ref_x, neg_x, car_x;
   cell_state_e             state;
   logic [3:0]              zero_gate;

   always_comb begin
      ref_x = CMP_W'(ref_i);
      neg_x = -ref_x;
      car_x = $signed(CMP_W'(carrier_i));
      if (ref_x > car_x)      state = CELL_POS;
      else if (neg_x > car_x) state = CELL_NEG;
      else                    state = CELL_ZERO;
   end

   generate
      if (ZERO_LOW) begin : g_zero_low
         assign zero_gate = GATE_ZLO;
      end else begin : g_zero_sign
         assign zero_gate = ref_i[REF_W-1] ? GATE_ZLO : GATE_ZHI;
      end
   endgenerate

   always_comb begin
      if (bypass_i) begin
         gate_o  = GATE_ZLO;
         level_o = 2'sd0;
      end else begin
         unique case (state)
            CELL_POS: begin gate_o = GATE_POS;  level_o = 2'sd1;  end
            CELL_NEG: begin gate_o = GATE_NEG;  level_o = -2'sd1; end
            default:  begin gate_o = zero_gate; level_o = 2'sd0;  end
         endcase
      end
   end

   // R6
   leg_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(gate_o[0] && gate_o[1]) && !(gate_o[2] && gate_o[3]));
endmodule

// File: rtl/pscar_bypass_sync.sv
module pscar_bypass_sync #(
   parameter int N_CELLS = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               boundary_i,
   input  logic [N_CELLS-1:0] bypass_i,
   output logic [N_CELLS-1:0] mask_o
);
   logic [N_CELLS-1:0] mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          mask_q <= '0;
      else if (boundary_i) mask_q <= bypass_i;
   end

   assign mask_o = mask_q;

   // R9
   mask_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_o != $past(mask_o)) |-> $past(boundary_i));
endmodule

// File: rtl/pscar_modulator.sv
module pscar_modulator
   import pscar_pkg::*;
#(
   parameter int N_CELLS  = 3,
   parameter int PEAK     = 12,
   parameter int REF_W    = 6,
   parameter bit ZERO_LOW = 1'b0
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic signed [REF_W-1:0]                ref_i,
   input  logic [N_CELLS-1:0]                     bypass_i,
   output logic [4*N_CELLS-1:0]                   gate_o,
   output logic signed [$clog2(N_CELLS+1):0]      level_o
);
   localparam int PH_W  = $clog2(2*PEAK);
   localparam int CAR_W = $clog2(PEAK+1);
   localparam int LVL_W = $clog2(N_CELLS+1) + 1;
   localparam int STEP  = PEAK / N_CELLS;

   generate
      if (N_CELLS < 1) begin : g_bad_cells
         $error("pscar_modulator: N_CELLS must be at least 1");
      end
      if (PEAK < 2 || (PEAK % N_CELLS) != 0) begin : g_bad_peak
         $error("pscar_modulator: PEAK must be >= 2 and a multiple of N_CELLS");
      end
      if (REF_W < CAR_W + 1) begin : g_bad_ref
         $error("pscar_modulator: REF_W too narrow to span the carrier");
      end
   endgenerate

   logic [PH_W-1:0]   phase   [N_CELLS];
   logic [CAR_W-1:0]  carrier [N_CELLS];
   logic signed [1:0] cell_lvl[N_CELLS];
   logic [N_CELLS-1:0] mask;

   generate
      for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
         pscar_carrier #(
            .PEAK(PEAK), .OFFSET(i*STEP), .PH_W(PH_W), .CAR_W(CAR_W)
         ) carrier_i (
            .clk(clk), .rst_n(rst_n), .phase_o(phase[i]), .carrier_o(carrier[i])
         );

         pscar_cell #(
            .CAR_W(CAR_W), .REF_W(REF_W), .ZERO_LOW(ZERO_LOW)
         ) cell_i (
            .clk(clk), .rst_n(rst_n), .ref_i(ref_i), .carrier_i(carrier[i]),
            .bypass_i(mask[i]), .gate_o(gate_o[4*i +: 4]), .level_o(cell_lvl[i])
         );

         if (i > 0) begin : g_gap
            // R2
            phase_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
               ((int'(phase[i]) - int'(phase[i-1]) + 2*PEAK) % (2*PEAK)) == STEP);
         end
      end
   endgenerate

   pscar_bypass_sync #(.N_CELLS(N_CELLS)) sync_i (
      .clk(clk), .rst_n(rst_n),
      .boundary_i(phase[0] == PH_W'(2*PEAK-1)),
      .bypass_i(bypass_i), .mask_o(mask)
   );

   always_comb begin
      level_o = '0;
      for (int i = 0; i < N_CELLS; i++) level_o = level_o + LVL_W'(cell_lvl[i]);
   end

   // R7
   level_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(level_o) <= N_CELLS - $countones(mask)) && (int'(level_o) >= $countones(mask) - N_CELLS));
endmodule

// File: tb/pscar_modulator_tb.sv
`timescale 1ns/1ps
module pscar_modulator_tb_top;
   localparam int N    = 3;
   localparam int P    = 12;
   localparam int RW   = 6;
   localparam int STEP = P / N;

   typedef struct packed {
      logic signed [7:0] refv;
      logic [2:0]        byp;
      logic [7:0]        ncyc;
      logic [3:0]        req;
   } vec_t;

   localparam vec_t VECS [9] = '{
      '{refv: 8'sd13,  byp: 3'b000, ncyc: 8'd24, req: 4'd3},  // R3 all positive
      '{refv: -8'sd13, byp: 3'b000, ncyc: 8'd24, req: 4'd4},  // R4 all negative
      '{refv: 8'sd0,   byp: 3'b000, ncyc: 8'd24, req: 4'd5},  // R5 zero, high pair
      '{refv: 8'sd6,   byp: 3'b000, ncyc: 8'd48, req: 4'd7},  // R7 mixed sum
      '{refv: -8'sd5,  byp: 3'b000, ncyc: 8'd48, req: 4'd5},  // R5 low pair on negative
      '{refv: 8'sd6,   byp: 3'b010, ncyc: 8'd48, req: 4'd8},  // R8 middle bypassed
      '{refv: -8'sd13, byp: 3'b101, ncyc: 8'd48, req: 4'd8},  // R8 outer bypassed
      '{refv: 8'sd12,  byp: 3'b000, ncyc: 8'd48, req: 4'd9},  // R9 restore, ref at peak
      '{refv: -8'sd12, byp: 3'b000, ncyc: 8'd24, req: 4'd4}   // R4 ref at negative peak
   };

   logic                  clk = 1'b0;
   logic                  rst_n = 1'b0;
   logic signed [RW-1:0]  ref_i = '0;
   logic [N-1:0]          bypass_i = '0;
   logic [4*N-1:0]        gate_o;
   logic signed [2:0]     level_o;

   int checks = 0;
   int failures = 0;
   int k_m = 0;
   logic [N-1:0] mask_m = '0;

   always #5 clk = ~clk;

   pscar_modulator #(.N_CELLS(N), .PEAK(P), .REF_W(RW)) dut_i (
      .clk(clk), .rst_n(rst_n), .ref_i(ref_i), .bypass_i(bypass_i),
      .gate_o(gate_o), .level_o(level_o)
   );

   // Bench model of R1 timing and R9/R10 bypass state
   always @(posedge clk) begin
      if (!rst_n) begin
         k_m    <= 0;
         mask_m <= '0;
      end else begin
         if (k_m % (2*P) == 2*P-1) mask_m <= bypass_i;
         k_m <= k_m + 1;
      end
   end

   function automatic int carrier_of(int i, int k);
      int ph = (i*STEP + k) % (2*P);
      return (ph < P) ? ph : 2*P - ph;
   endfunction

   task automatic check(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
      end
   endtask

   task automatic check_all(string req);
      logic [4*N-1:0] eg;
      int el;
      int r;
      bit legs_ok;
      eg = '0;
      el = 0;
      r = int'(ref_i);
      for (int i = 0; i < N; i++) begin
         int c = carrier_of(i, k_m);
         if (mask_m[i])   eg[4*i +: 4] = 4'b1010;
         else if (r > c)  begin eg[4*i +: 4] = 4'b1001; el++; end
         else if (-r > c) begin eg[4*i +: 4] = 4'b0110; el--; end
         else             eg[4*i +: 4] = (r < 0) ? 4'b1010 : 4'b0101;
      end
      check(gate_o == eg, {req, " gates"}, int'(gate_o), int'(eg));
      check(int'(level_o) == el, {req, " level"}, int'(level_o), el);
      legs_ok = 1'b1;
      for (int i = 0; i < N; i++)
         if ((gate_o[4*i] && gate_o[4*i+1]) || (gate_o[4*i+2] && gate_o[4*i+3])) legs_ok = 1'b0;
      check(legs_ok, "R6 leg exclusive", int'(gate_o), 0);
   endtask

   initial begin
      #2_000_000;
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      // R1: reset state, carriers at 0,4,8
      @(negedge clk); ref_i = 0; #1 check_all("R1");
      // R2: ref 5 beats carriers 0 and 4 only; ref 4 ties cell 1
      @(negedge clk); ref_i = 5; #1 check_all("R2");
      check(level_o == 3'sd2, "R2 offset level", int'(level_o), 2);
      @(negedge clk); ref_i = 4; #1 check_all("R2");
      check(level_o == 3'sd1, "R2 tie level", int'(level_o), 1);
      @(negedge clk); rst_n = 1'b1; #1 check_all("R1");

      // Table walk
      foreach (VECS[v]) begin
         @(negedge clk);
         ref_i    = RW'(VECS[v].refv);
         bypass_i = VECS[v].byp;
         #1 check_all($sformatf("R%0d", VECS[v].req));
         for (int c = 1; c < int'(VECS[v].ncyc); c++) begin
            @(negedge clk); #1 check_all($sformatf("R%0d", VECS[v].req));
         end
      end

      // R9: request bypass mid-period, takes effect only after the wrap
      @(negedge clk); bypass_i = '0; ref_i = 13;
      while (k_m % (2*P) != 0) begin @(negedge clk); end
      while (k_m % (2*P) != 5) begin @(negedge clk); end
      bypass_i = 3'b001;
      while (k_m % (2*P) != 0) begin
         #1 check(level_o == 3'sd3, "R9 held before wrap", int'(level_o), 3);
         check_all("R9");
         @(negedge clk);
      end
      #1 check(level_o == 3'sd2, "R9 applied at wrap", int'(level_o), 2);
      check(gate_o[3:0] == 4'b1010, "R8 bypassed nibble", int'(gate_o[3:0]), 10);

      // R8: all bypassed gives level 0
      @(negedge clk); bypass_i = 3'b111;
      while (k_m % (2*P) != 0) begin @(negedge clk); end
      #1 check(level_o == 3'sd0, "R8 all bypassed", int'(level_o), 0);
      check_all("R8");

      // R10: reset clears bypass state despite request
      rst_n = 1'b0;
      @(posedge clk); @(negedge clk);
      #1 check(level_o == 3'sd3, "R10 cleared in reset", int'(level_o), 3);
      check_all("R10");
      rst_n = 1'b1;
      for (int c = 0; c < 2*P + 2; c++) begin
         @(negedge clk); #1 check_all("R10");
      end
      check(level_o == 3'sd0, "R10 request reapplied at wrap", int'(level_o), 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule